// File: doc/BRIEF.md
# Multi-Lane Monitor Polling Sequencer

This block collects optical and electrical monitoring bytes from small monitor chips on a two-wire bus and writes them into a local register file. It drives the two-wire bus through a bus master that works at byte level. The block issues single-byte read requests, each with a device address and a memory offset, and receives a data byte or a NACK in reply. The bit-level signalling on the wire is handled outside this block.

The block has two modes. In direct mode it reads one monitor device whose contents already cover every lane. In indirect mode it visits four per-lane devices one after another, reads a ten-byte group from each into that lane's own area, and then mirrors the group of one chosen lane into a summary area. No range comparison decides which lane that is. A configuration field names it. A poll cycle can be launched on demand, or by default it repeats after a programmable idle interval.

A NACK ends the current cycle at once. The summary keeps its earlier contents, and a sticky error flag is raised.

Top module: `mon_poll_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy`, `err`, `req_valid` and `wr_en` are all low.
- R2: In indirect mode (`cfg_indirect`=1), lanes are polled in the order 0, 1, 2, 3. For each lane, ten bytes are read from that lane's device address (`cfg_lane_dev` bits [7k+6:7k]) at offsets `cfg_lane_off`[8k+7:8k] + i, for i = 0..9. Byte i of lane k is written to register address `LANE_BASE` + 16·k + i.
- R3: After all forty lane bytes are written, the group of the lane selected by `cfg_rep_lane` (value 0..3) is copied. Bytes 0..7 go to `SUM_VAL_BASE`+0..7, then bytes 8 and 9, which are the alarm and status flag bytes, go to `SUM_FLAG_BASE`+0..1, in that order.
- R4: In direct mode (`cfg_indirect`=0), ten bytes are read from `cfg_direct_dev` at `cfg_direct_off`+i. They are written only to the summary addresses of R3, and nothing is written to any lane area.
- R5: A response with `rsp_nack`=1 ends the cycle. No further register writes follow, so the summary keeps its old values. `err` goes high and stays high through later good cycles until reset.
- R6: `busy` rises in the cycle after a launch and stays high through the last register write of the cycle, including the last summary write. `req_valid` and `wr_en` are only high while `busy` is high.
- R7: With `cfg_one_shot`=0, a new cycle starts after `busy` has been low for exactly (`cfg_rate`+1)·2^`PER_SHIFT` cycles. With `cfg_one_shot`=1, a cycle starts only on a `start` pulse.
- R8: A request is held, with `req_dev` and `req_addr` unchanged, until it is accepted by `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one poll cycle when idle |
| cfg_indirect | input | 1 | 1 = four per-lane devices, 0 = one direct device |
| cfg_one_shot | input | 1 | 0 = periodic repeat (default), 1 = on demand only |
| cfg_rate | input | RATE_W | Repeat interval select |
| cfg_rep_lane | input | 2 | Lane mirrored into the summary area |
| cfg_direct_dev | input | 7 | Device address in direct mode |
| cfg_direct_off | input | 8 | Start offset in direct mode |
| cfg_lane_dev | input | 28 | Four per-lane device addresses, lane k at bits [7k+6:7k] |
| cfg_lane_off | input | 32 | Four per-lane start offsets, lane k at bits [8k+7:8k] |
| req_valid | output | 1 | Byte read request to the bus master |
| req_ready | input | 1 | Bus master accepts the request |
| req_dev | output | 7 | Device address of the request |
| req_addr | output | 8 | Memory offset of the request |
| rsp_valid | input | 1 | Response present |
| rsp_nack | input | 1 | Device did not acknowledge |
| rsp_data | input | 8 | Byte read |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | 8 | Register-file write address |
| wr_data | output | 8 | Register-file write data |
| busy | output | 1 | Poll cycle in progress |
| err | output | 1 | Sticky bus error flag |

## Verification
The bound checker checks on every cycle that a stalled request holds its device and offset, that requests and writes occur only while `busy` is high, and that the error flag never drops outside reset. Some behaviours can only be shown by the bench's scenarios: the exact write order and addresses for each lane and for the summary, the choice of representative lane, the lack of lane writes in direct mode, the missing summary after a NACK on a middle lane, and the exact length of the periodic idle gap. The bench checks these against a scoreboard built from the requirements.

// File: rtl/mon_poll_pkg.sv
package mon_poll_pkg;
    localparam int NLANES     = 4;
    localparam int BLK_BYTES  = 10;
    localparam int FLAG_BYTES = 2;
    localparam int VAL_BYTES  = BLK_BYTES - FLAG_BYTES;
    localparam int DEV_W      = 7;
    localparam int ADR_W      = 8;
    localparam int DAT_W      = 8;
    localparam int IDX_W      = $clog2(BLK_BYTES);
    localparam int LANE_W     = $clog2(NLANES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_COPY
    } seq_st_e;

    typedef struct packed {
        logic             vld;
        logic [ADR_W-1:0] addr;
        logic [DAT_W-1:0] data;
    } rf_wr_t;

    // Summary placement: value bytes first, then flag bytes in their own area.
    function automatic logic [ADR_W-1:0] sum_addr(
        input logic [IDX_W-1:0] i,
        input logic [ADR_W-1:0] val_base,
        input logic [ADR_W-1:0] flag_base
    );
        if (i < IDX_W'(VAL_BYTES))
            return val_base + ADR_W'(i);
        else
            return flag_base + ADR_W'(i - IDX_W'(VAL_BYTES));
    endfunction
endpackage

// File: rtl/mp_timer.sv
module mp_timer #(
    parameter int RATE_W    = 4,
    parameter int PER_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              fire
);
    localparam int CW = RATE_W + PER_SHIFT + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;

    assign period = (CW'(rate) + CW'(1)) << PER_SHIFT;
    assign fire   = run && (cnt == period - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/mp_shadow.sv
module mp_shadow
    import mon_poll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [DAT_W-1:0] cap_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DAT_W-1:0] rd_data
);
    logic [DAT_W-1:0] held [BLK_BYTES];

    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (cap_en && cap_idx == IDX_W'(g))
                held[g] <= cap_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < BLK_BYTES; k++)
            if (rd_idx == IDX_W'(k)) rd_data = held[k];
    end
endmodule

// File: rtl/mp_engine.sv
module mp_engine
    import mon_poll_pkg::*;
#(
    parameter int LANE_BASE     = 'hC0,
    parameter int LANE_STRIDE   = 16,
    parameter int SUM_VAL_BASE  = 'h60,
    parameter int SUM_FLAG_BASE = 'h70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              cfg_indirect,
    input  logic [LANE_W-1:0] cfg_rep_lane,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [DAT_W-1:0]  rsp_data,
    input  logic [DAT_W-1:0]  shadow_rd,
    output logic              req_valid,
    output logic [LANE_W-1:0] lane,
    output logic [IDX_W-1:0]  idx,
    output logic              run_ind,
    output logic              cap_en,
    output rf_wr_t            wr,
    output logic              err,
    output logic              busy
);
    seq_st_e           st;
    logic [LANE_W-1:0] lane_q;
    logic [LANE_W-1:0] rep_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ind_q;
    logic              err_q;
    rf_wr_t            wr_q;
    logic              last_byte;
    logic              last_lane;
    logic [ADR_W-1:0]  lane_addr;

    assign last_byte = (idx_q == IDX_W'(BLK_BYTES - 1));
    assign last_lane = (lane_q == LANE_W'(NLANES - 1));
    assign lane_addr = ADR_W'(LANE_BASE) + ADR_W'(lane_q) * ADR_W'(LANE_STRIDE) + ADR_W'(idx_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            lane_q <= '0;
            rep_q  <= '0;
            idx_q  <= '0;
            ind_q  <= 1'b0;
            err_q  <= 1'b0;
            wr_q   <= '0;
        end else begin
            wr_q.vld <= 1'b0;
            unique case (st)
                ST_IDLE: if (launch) begin
                    ind_q  <= cfg_indirect;
                    rep_q  <= cfg_rep_lane;
                    lane_q <= '0;
                    idx_q  <= '0;
                    st     <= ST_REQ;
                end
                ST_REQ: if (req_ready) st <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    if (rsp_nack) begin
                        err_q <= 1'b1;
                        st    <= ST_IDLE;
                    end else begin
                        if (ind_q) wr_q <= '{vld: 1'b1, addr: lane_addr, data: rsp_data};
                        if (last_byte) begin
                            idx_q <= '0;
                            if (!ind_q || last_lane) begin
                                st <= ST_COPY;
                            end else begin
                                lane_q <= lane_q + LANE_W'(1);
                                st     <= ST_REQ;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            st    <= ST_REQ;
                        end
                    end
                end
                ST_COPY: begin
                    wr_q <= '{vld: 1'b1,
                              addr: sum_addr(idx_q, ADR_W'(SUM_VAL_BASE), ADR_W'(SUM_FLAG_BASE)),
                              data: shadow_rd};
                    if (last_byte) begin
                        idx_q <= '0;
                        st    <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cap_en    = (st == ST_WAIT) && rsp_valid && !rsp_nack && (!ind_q || lane_q == rep_q);
    assign req_valid = (st == ST_REQ);
    assign lane      = lane_q;
    assign idx       = idx_q;
    assign run_ind   = ind_q;
    assign wr        = wr_q;
    assign err       = err_q;
    assign busy      = (st != ST_IDLE) || wr_q.vld;
endmodule

// File: rtl/mon_poll_seq.sv
module mon_poll_seq
    import mon_poll_pkg::*;
#(
    parameter int RATE_W        = 4,
    parameter int PER_SHIFT     = 6,
    parameter int LANE_BASE     = 'hC0,
    parameter int LANE_STRIDE   = 16,
    parameter int SUM_VAL_BASE  = 'h60,
    parameter int SUM_FLAG_BASE = 'h70
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      cfg_indirect,
    input  logic                      cfg_one_shot,
    input  logic [RATE_W-1:0]         cfg_rate,
    input  logic [1:0]                cfg_rep_lane,
    input  logic [6:0]                cfg_direct_dev,
    input  logic [7:0]                cfg_direct_off,
    input  logic [27:0]               cfg_lane_dev,
    input  logic [31:0]               cfg_lane_off,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [6:0]                req_dev,
    output logic [7:0]                req_addr,
    input  logic                      rsp_valid,
    input  logic                      rsp_nack,
    input  logic [7:0]                rsp_data,
    output logic                      wr_en,
    output logic [7:0]                wr_addr,
    output logic [7:0]                wr_data,
    output logic                      busy,
    output logic                      err
);
    logic              fire;
    logic              launch;
    logic [LANE_W-1:0] lane;
    logic [IDX_W-1:0]  idx;
    logic              run_ind;
    logic              cap_en;
    logic [DAT_W-1:0]  shadow_rd;
    rf_wr_t            wr;
    logic [ADR_W-1:0]  base_off;

    mp_timer #(.RATE_W(RATE_W), .PER_SHIFT(PER_SHIFT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!cfg_one_shot && !busy),
        .rate (cfg_rate),
        .fire (fire)
    );

    assign launch = start || fire;

    mp_engine #(
        .LANE_BASE    (LANE_BASE),
        .LANE_STRIDE  (LANE_STRIDE),
        .SUM_VAL_BASE (SUM_VAL_BASE),
        .SUM_FLAG_BASE(SUM_FLAG_BASE)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .cfg_indirect(cfg_indirect),
        .cfg_rep_lane(cfg_rep_lane),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_nack    (rsp_nack),
        .rsp_data    (rsp_data),
        .shadow_rd   (shadow_rd),
        .req_valid   (req_valid),
        .lane        (lane),
        .idx         (idx),
        .run_ind     (run_ind),
        .cap_en      (cap_en),
        .wr          (wr),
        .err         (err),
        .busy        (busy)
    );

    mp_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_idx (idx),
        .cap_data(rsp_data),
        .rd_idx  (idx),
        .rd_data (shadow_rd)
    );

    assign req_dev  = run_ind ? cfg_lane_dev[DEV_W*lane +: DEV_W] : cfg_direct_dev;
    assign base_off = run_ind ? cfg_lane_off[ADR_W*lane +: ADR_W] : cfg_direct_off;
    assign req_addr = base_off + ADR_W'(idx);

    assign wr_en   = wr.vld;
    assign wr_addr = wr.addr;
    assign wr_data = wr.data;
endmodule

// File: rtl/mon_poll_chk.sv
module mon_poll_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [6:0] req_dev,
    input logic [7:0] req_addr,
    input logic       wr_en,
    input logic       busy,
    input logic       err
);
    // R8: a request that is not accepted is held unchanged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_dev) && $stable(req_addr));

    // R6: writes only while busy
    a_r6_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R6: requests only while busy
    a_r6_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    // R5: error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R1: quiet outputs right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !err && !req_valid && !wr_en);
endmodule

bind mon_poll_seq mon_poll_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_dev  (req_dev),
    .req_addr (req_addr),
    .wr_en    (wr_en),
    .busy     (busy),
    .err      (err)
);

// File: tb/sim_mon_poll_seq.sv
module sim_mon_poll_seq;
    localparam int PER_SHIFT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cfg_indirect = 1'b1;
    logic        cfg_one_shot = 1'b1;
    logic [3:0]  cfg_rate = 4'd0;
    logic [1:0]  cfg_rep_lane = 2'd0;
    logic [6:0]  cfg_direct_dev = 7'h48;
    logic [7:0]  cfg_direct_off = 8'h20;
    logic [27:0] cfg_lane_dev;
    logic [31:0] cfg_lane_off;
    logic        req_valid, req_ready = 1'b0;
    logic [6:0]  req_dev;
    logic [7:0]  req_addr;
    logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        wr_en, busy, err;
    logic [7:0]  wr_addr, wr_data;
    logic [6:0]  nack_dev = 7'h7F;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] a; logic [7:0] d; int r; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mon_poll_seq #(.PER_SHIFT(PER_SHIFT)) u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_indirect(cfg_indirect),
        .cfg_one_shot(cfg_one_shot), .cfg_rate(cfg_rate), .cfg_rep_lane(cfg_rep_lane),
        .cfg_direct_dev(cfg_direct_dev), .cfg_direct_off(cfg_direct_off),
        .cfg_lane_dev(cfg_lane_dev), .cfg_lane_off(cfg_lane_off),
        .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .err(err)
    );

    function automatic logic [7:0] fdat(input logic [6:0] dev, input logic [7:0] a);
        return (8'(dev) * 8'd3) ^ (a * 8'd5) ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] d, input int r);
        exp_t e;
        e.a = a; e.d = d; e.r = r;
        sb.push_back(e);
    endtask

    // Expected writes for one poll cycle; nack_lane = 4 means no NACK.
    task automatic expect_cycle(input bit ind, input int rep, input int nack_lane);
        logic [6:0] dv;
        logic [7:0] of;
        if (ind) begin
            for (int k = 0; k < 4; k++) begin
                if (k == nack_lane) return;
                dv = cfg_lane_dev[7*k +: 7];
                of = cfg_lane_off[8*k +: 8];
                for (int i = 0; i < 10; i++)
                    push(8'hC0 + 8'(16 * k + i), fdat(dv, of + 8'(i)), 2);
            end
            dv = cfg_lane_dev[7*rep +: 7];
            of = cfg_lane_off[8*rep +: 8];
        end else begin
            dv = cfg_direct_dev;
            of = cfg_direct_off;
        end
        for (int i = 0; i < 10; i++)
            push(i < 8 ? 8'h60 + 8'(i) : 8'h70 + 8'(i - 8), fdat(dv, of + 8'(i)), ind ? 3 : 4);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic run_once(input bit ind, input int rep, input int nack_lane);
        cfg_indirect = ind;
        cfg_rep_lane = 2'(rep);
        expect_cycle(ind, rep, nack_lane);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R6 busy after launch", int'(busy), 1);
        wait_idle();
        check(sb.size() == 0, "R2/R3 all expected writes seen", sb.size(), 0);
    endtask

    // Monitor: compare each register write against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            check(busy === 1'b1, "R6 busy during write", int'(busy), 1);
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected write", int'(wr_addr), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(wr_addr === e.a && wr_data === e.d, $sformatf("R%0d write", e.r),
                      int'({wr_addr, wr_data}), int'({e.a, e.d}));
            end
        end
    end

    // Bus model: stall each request one cycle, then accept and answer.
    initial begin
        logic [6:0] sd;
        logic [7:0] sa;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_nack  = 1'b0;
            if (!rst && req_valid) begin
                sd = req_dev;
                sa = req_addr;
                @(negedge clk);
                check(req_valid === 1'b1 && req_dev === sd && req_addr === sa,
                      "R8 request held while stalled", int'({req_dev, req_addr}), int'({sd, sa}));
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                rsp_valid = 1'b1;
                rsp_nack  = (sd == nack_dev);
                rsp_data  = fdat(sd, sa);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int gap;
        cfg_lane_dev = {7'h53, 7'h52, 7'h51, 7'h50};
        cfg_lane_off = {8'h40, 8'h30, 8'h10, 8'h00};
        repeat (3) @(negedge clk);
        check(!busy && !err && !req_valid && !wr_en, "R1 outputs in reset",
              int'({busy, err, req_valid, wr_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !err && !req_valid && !wr_en, "R1 outputs after reset",
              int'({busy, err, req_valid, wr_en}), 0);

        // R2/R3: indirect, representative lane 2
        run_once(1'b1, 2, 4);
        // R2/R3: other offsets, representative lane 0 and 3
        cfg_lane_off = {8'hF8, 8'h05, 8'h77, 8'hA0};
        run_once(1'b1, 0, 4);
        run_once(1'b1, 3, 4);
        // R4: direct mode
        run_once(1'b0, 1, 4);
        check(err === 1'b0, "R5 no error yet", int'(err), 0);

        // R5: NACK on lane 2 aborts before any summary write
        nack_dev = 7'h52;
        run_once(1'b1, 1, 2);
        check(err === 1'b1, "R5 error set after NACK", int'(err), 1);
        nack_dev = 7'h7F;
        run_once(1'b1, 1, 4);
        check(err === 1'b1, "R5 error sticky after good cycle", int'(err), 1);

        // R7: one-shot mode never launches by itself
        repeat (300) begin
            @(negedge clk);
            if (busy) break;
        end
        check(busy === 1'b0, "R7 no launch in one-shot mode", int'(busy), 0);

        // R7: periodic mode, interval (1+1)*2^PER_SHIFT
        cfg_indirect = 1'b1;
        cfg_rep_lane = 2'd1;
        cfg_rate     = 4'd1;
        expect_cycle(1'b1, 1, 4);
        expect_cycle(1'b1, 1, 4);
        cfg_one_shot = 1'b0;
        do @(negedge clk); while (!busy);
        wait_idle();
        gap = 0;
        while (!busy) begin
            gap++;
            @(negedge clk);
        end
        check(gap == 2 << PER_SHIFT, "R7 periodic idle gap", gap, 2 << PER_SHIFT);
        cfg_one_shot = 1'b1;
        wait_idle();
        check(sb.size() == 0, "R7 both periodic cycles written", sb.size(), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule